// File: doc/BRIEF.md
# Audio Sample Delay Line

This block holds back a stream of 12-bit audio samples by a fixed number of sample-clock cycles. One sample is accepted on each rising clock edge, and it reappears on the output exactly `DELAY` edges later. With a 20 kHz sample clock and the default `DELAY` of 5000, the delay is 0.25 s.

The stored samples are never shifted. They sit in an inferred single-clock memory of `DELAY + 2` entries. A write pointer and a read pointer step through that memory, and each returns to address 0 after the last entry. The write pointer moves on every cycle. The read pointer stays at address 0 until the write pointer first reaches the value `DELAY`. From then on, both pointers advance on every cycle. The memory read is registered, and that register is the output.

A synchronous reset restarts the fill. After a reset the output stays at zero and the valid flag stays low until the first sample taken after that reset comes out.

Top module: `audio_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `sample_out` to 0 and `out_valid` to 0.
- R2: Number the edges after reset release from 0, where edge 0 is the first rising edge with `rst` low. `out_valid` is low after edges 0 to `DELAY-1` and goes high at edge `DELAY`.
- R3: When `out_valid` is high after edge n, `sample_out` equals the `sample_in` value taken at edge n-`DELAY`.
- R4: Once `out_valid` is high, it stays high until the next reset.
- R5: The memory has `DELAY+2` entries and both pointers return to 0 after the last entry. R3 keeps holding for many more than `DELAY+2` cycles, across several wraparounds of both pointers.
- R6: While `out_valid` is low, `sample_out` holds 0.
- R7: A reset applied mid-stream restarts the fill. No sample taken before the reset ever reaches the output after it, and the first valid output is the first sample taken after reset release.
- R8: Every bit of the 12-bit sample passes unchanged, including 0x000, 0xFFF and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | SAMPLE_W (12) | Incoming audio sample |
| sample_out | output | SAMPLE_W (12) | Sample delayed by DELAY cycles |
| out_valid | output | 1 | High once the first delayed sample is present |

## Verification
The in-line assertions check, on every cycle, these behaviours:
- the reset values;
- that the valid flag never drops without a reset;
- that it rises only on the edge where the write pointer sits at `DELAY`;
- that the write pointer wraps after the last entry;
- that once running, the read pointer stays two entries ahead of the write pointer, modulo the depth.

Only the bench's scenarios can show that the data is actually correct. The bench's scenarios drive a counting sequence, extreme and alternating bit patterns, and pseudo-random samples over several wraparounds, with a reset in mid-stream. These scenarios show the exact `DELAY`-cycle latency and that no stale sample survives a reset.

// File: rtl/audio_delay_line.sv
module audio_delay_line #(
  parameter int SAMPLE_W = 12,
  parameter int DELAY    = 5000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                out_valid
);
  localparam int DEPTH = DELAY + 2;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] START = AW'(DELAY);

  if (DELAY < 1) begin : g_bad_delay
    $error("DELAY must be at least 1");
  end

  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          rd_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign rd_en = out_valid || (wr_ptr == START);

  always_ff @(posedge clk)
    store[wr_ptr] <= sample_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      sample_out <= '0;
      out_valid  <= 1'b0;
    end else begin
      wr_ptr <= step(wr_ptr);
      if (rd_en) begin
        rd_ptr     <= step(rd_ptr);
        sample_out <= store[rd_ptr];
        out_valid  <= 1'b1;
      end
    end
  end

  // R1: reset values
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sample_out == '0 && !out_valid));

  // R4: valid holds until reset
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R2: valid rises only on the edge where the write pointer reached DELAY
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(wr_ptr) == START);

  // R6: output stays zero until valid
  a_r6_zero_before_valid: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> sample_out == '0);

  // R5: write pointer wraps after the last entry
  a_r5_wr_wrap: assert property (@(posedge clk) disable iff (rst)
    wr_ptr == LAST |=> wr_ptr == '0);

  // R3: read pointer leads write pointer by two entries once running
  a_r3_ptr_gap: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(rd_ptr) == (int'(wr_ptr) + 2) % DEPTH);
endmodule

// File: tb/test_audio_delay_line.sv
module test_audio_delay_line;
  localparam int W     = 12;
  localparam int DELAY = 5000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] sample_out;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit last_rst = 1'b1;
  bit after_reset = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  audio_delay_line #(.SAMPLE_W(W), .DELAY(DELAY)) i_audio_delay_line (
    .clk(clk), .rst(rst), .sample_in(sample_in),
    .sample_out(sample_out), .out_valid(out_valid));

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edges);
  endtask

  task automatic monitor();
    logic [W-1:0] e;
    if (last_rst) begin
      checks++;
      if (sample_out !== '0 || out_valid !== 1'b0)
        fail("R1", {out_valid, sample_out}, 0);
      return;
    end
    checks++;
    if (out_valid !== (edges > DELAY))
      fail(edges > DELAY ? "R4" : "R2", out_valid, edges > DELAY);
    if (out_valid !== 1'b1) begin
      checks++;
      if (sample_out !== '0) fail("R6", sample_out, 0);
      return;
    end
    if (expq.size() == 0) begin
      checks++;
      fail("R3", sample_out, -1);
      return;
    end
    e = expq.pop_front();
    checks++;
    if (sample_out !== e) begin
      if (after_reset)            fail("R7", sample_out, e);
      else if (edges > DELAY + 2) fail("R5", sample_out, e);
      else                        fail("R3", sample_out, e);
    end
    after_reset = 1'b0;
  endtask

  task automatic drive(input bit r, input logic [W-1:0] s);
    @(negedge clk);
    monitor();
    rst = r;
    sample_in = s;
    last_rst = r;
    if (r) begin
      expq.delete();
      edges = 0;
    end else begin
      expq.push_back(s);
      edges++;
    end
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 12'hABC);
    after_reset = 1'b1;
  endtask

  initial begin
    do_reset(4);
    // R2 R3 R5: counting sequence over several wraparounds
    for (int i = 0; i < 4 * (DELAY + 2) + 100; i++) drive(1'b0, W'(i));
    // R8: extreme and alternating patterns
    for (int i = 0; i < DELAY + 50; i++)
      case (i % 4)
        0: drive(1'b0, 12'hFFF);
        1: drive(1'b0, 12'h000);
        2: drive(1'b0, 12'hAAA);
        default: drive(1'b0, 12'h555);
      endcase
    // R7: reset mid-stream, then pseudo-random data
    do_reset(3);
    for (int i = 0; i < 2 * (DELAY + 2) + 30; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(1'b0, lfsr[W-1:0]);
    end
    drive(1'b0, '0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule